// File: doc/BRIEF.md
# Command Queue Packet Engine

This block sends one link command at a time to a downstream packetizer. Software writes up to 64 32-bit words into a queue window, sets the queue length and operating mode, and then writes a start bit. The engine turns queue word 0 into a three-byte header. If word 0 asks for it, the engine follows the header with a payload taken from queue word 1 onward. All bytes leave one per cycle on a valid/ready byte stream. Error-correcting codes, checksums and the physical lanes are handled downstream.

When word 0 asks for a turnaround read, the engine sends the header and then waits for a four-word response on the receive input. It latches that response into four read-data registers. It then raises both the read-ready flag and the command-done flag, and it stays busy until software writes a read-acknowledge. An interrupt status register holds six sticky flags, each with its own enable bit. A flag is cleared by writing 0 to it. The register also shows a read-only busy bit.

The sequencer has four states:
- `ST_IDLE`: waits for an accepted start.
- `ST_SEND`: streams the header and payload bytes.
- `ST_WAIT_RX`: collects the read response.
- `ST_WAIT_ACK`: holds busy until the acknowledge arrives.

Its transitions are:
- start accepted: `ST_IDLE` to `ST_SEND`.
- last byte taken on a write: `ST_SEND` to `ST_IDLE`.
- last byte taken on a read: `ST_SEND` to `ST_WAIT_RX`.
- fourth response word: `ST_WAIT_RX` to `ST_WAIT_ACK`.
- acknowledge: `ST_WAIT_ACK` to `ST_IDLE`.

Top module: `cmdq_pkt_engine`

Register word addresses (bus_addr):

| Address | Contents |
|---|---|
| 0 | control; bit 0 = start |
| 1 | mode, bits 1:0 |
| 2 | queue size, bits 5:0 |
| 3 | interrupt enables, bits 5:0 |
| 4 | status; bits 5:0 = flags, bit 31 = busy |
| 5 | acknowledge; bit 0 |
| 8 to 11 | read-data words 0 to 3 |
| 64 to 127 | queue words 0 to 63 |

Status flag bits are:
- bit 0: read ready
- bit 1: command done
- bit 2: tear-effect ready
- bit 3: video done
- bit 4: external tear-effect ready
- bit 5: start-while-busy error

## Requirements
- R1: Queue word 0 holds a configuration byte in bits 7:0, a data identifier in bits 15:8, and two parameter or length bytes in bits 31:16. The header goes out as bits 15:8, then 23:16, then 31:24.
- R2: A configuration byte with bit 1 clear gives a three-byte short packet. With bit 1 set, the packet is long: after the header come exactly len = word0[31:16] payload bytes. They are read least significant byte first from queue word 1 onward, and unused bytes of the last word are not sent. tx_last marks the final byte of every packet.
- R3: With configuration bit 2 set, the engine sends the header and then takes the next four rx_valid words into read-data words 0 to 3 in arrival order. On the edge that takes the fourth word, it sets status bits 0 and 1 together.
- R4: Status bit 31 (busy) is 1 from an accepted start until the last byte is taken on a write. On a read it stays 1 until a write of 1 to acknowledge bit 0.
- R5: On a write command, status bit 1 is set on the edge where the last byte is accepted.
- R6: A start is ignored when the mode field is not 0 or when the 6-bit queue size is 0.
- R7: A start written while busy is ignored and sets sticky status bit 5.
- R8: A status write clears each flag written as 0 and keeps each flag written as 1; a set arriving in the same cycle wins. evt_set[2:0] sets status bits 2 to 4.
- R9: irq is 1 exactly when some status flag and its enable bit are both 1.
- R10: While tx_valid is high and tx_ready is low, the byte and tx_last are held.
- R11: Response words that arrive outside the response wait, and acknowledges written outside the acknowledge wait, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register or queue word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| evt_set | input | 3 | Event pulses for status bits 2 to 4 |
| tx_valid | output | 1 | Byte available to the packetizer |
| tx_ready | input | 1 | Packetizer accepts the byte |
| tx_byte | output | 8 | Outgoing byte |
| tx_last | output | 1 | Final byte of the packet |
| rx_valid | input | 1 | Response word valid |
| rx_word | input | 32 | Response word |
| irq | output | 1 | Interrupt request |

## Verification
Commands are tried in several forms:
- A short write separates header byte order from payload handling.
- Long writes of seven and zero payload bytes under steady and intermittent ready show whether partial final words are trimmed and bytes are held under backpressure.
- A turnaround read, with a start written during the response wait, tells the read path apart from the error flag. It also shows whether busy lasts until the acknowledge.
- Starts in a non-command mode or with an empty queue size, stray response words, stray acknowledges, and masked event pulses show that each gate and enable acts alone.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT_RX,
        ST_WAIT_ACK
    } seq_state_t;

    localparam int REG_CTRL  = 0;
    localparam int REG_MODE  = 1;
    localparam int REG_QSIZE = 2;
    localparam int REG_IEN   = 3;
    localparam int REG_STAT  = 4;
    localparam int REG_RACK  = 5;
    localparam int REG_RXD0  = 8;

    localparam int CFG_LONG_BIT = 1;
    localparam int CFG_READ_BIT = 2;

    localparam int N_FLAGS   = 6;
    localparam int FL_RDRDY  = 0;
    localparam int FL_DONE   = 1;
    localparam int FL_EVT0   = 2;
    localparam int FL_ERR    = 5;
    localparam int HDR_BYTES = 3;
endpackage

// File: rtl/cmdq_rxcap.sv
module cmdq_rxcap #(
    parameter int RX_WORDS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       arm,
    input  logic                       rx_valid,
    input  logic [31:0]                rx_word,
    output logic [RX_WORDS-1:0][31:0]  rx_regs,
    output logic                       rx_done
);
    localparam int CNT_W = (RX_WORDS > 1) ? $clog2(RX_WORDS) : 1;

    logic [CNT_W-1:0] beat;

    assign rx_done = arm && rx_valid && (beat == CNT_W'(RX_WORDS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (!arm) begin
            beat <= '0;
        end else if (rx_valid) begin
            beat <= rx_done ? '0 : beat + 1'b1;
        end
    end

    for (genvar w = 0; w < RX_WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rx_regs[w] <= '0;
            end else if (arm && rx_valid && beat == CNT_W'(w)) begin
                rx_regs[w] <= rx_word;
            end
        end
    end

    // R11: words outside the response wait leave the read-data registers alone
    assert_stray_rx_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !arm) |=> $stable(rx_regs));
endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
    import cmdq_pkg::*;
#(
    parameter int QSZ_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ok,
    input  logic [23:0]      hdr_in,
    input  logic             cfg_long,
    input  logic             cfg_read,
    input  logic [31:0]      pay_word,
    output logic [QSZ_W-1:0] qidx,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_byte,
    output logic             tx_last,
    input  logic             rx_done,
    input  logic             rack_req,
    output logic             arm_rx,
    output logic             wr_done,
    output logic             busy
);
    localparam int IDX_W = 17;

    seq_state_t       st, st_n;
    logic [23:0]      hdr;
    logic             is_read;
    logic [IDX_W-1:0] bidx, last_idx, pidx;
    logic             take;

    assign take = (st == ST_SEND) && tx_ready;

    // next-state
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:     if (start_ok) st_n = ST_SEND;
            ST_SEND:     if (take && bidx == last_idx) st_n = is_read ? ST_WAIT_RX : ST_IDLE;
            ST_WAIT_RX:  if (rx_done) st_n = ST_WAIT_ACK;
            ST_WAIT_ACK: if (rack_req) st_n = ST_IDLE;
            default:     st_n = ST_IDLE;
        endcase
    end

    // state register and byte counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            hdr      <= '0;
            is_read  <= 1'b0;
            bidx     <= '0;
            last_idx <= '0;
        end else begin
            st <= st_n;
            if (st == ST_IDLE && start_ok) begin
                hdr      <= hdr_in;
                is_read  <= cfg_read;
                bidx     <= '0;
                last_idx <= cfg_long ? ({1'b0, hdr_in[23:8]} + IDX_W'(HDR_BYTES - 1))
                                     : IDX_W'(HDR_BYTES - 1);
            end else if (take) begin
                bidx <= bidx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pidx     = bidx - IDX_W'(HDR_BYTES);
        qidx     = QSZ_W'(1) + pidx[QSZ_W+1:2];
        tx_valid = (st == ST_SEND);
        tx_last  = tx_valid && (bidx == last_idx);
        busy     = (st != ST_IDLE);
        arm_rx   = (st == ST_WAIT_RX);
        wr_done  = take && (bidx == last_idx) && !is_read;
        if (bidx < IDX_W'(HDR_BYTES)) begin
            unique case (bidx[1:0])
                2'd0:    tx_byte = hdr[7:0];
                2'd1:    tx_byte = hdr[15:8];
                default: tx_byte = hdr[23:16];
            endcase
        end else begin
            unique case (pidx[1:0])
                2'd0:    tx_byte = pay_word[7:0];
                2'd1:    tx_byte = pay_word[15:8];
                2'd2:    tx_byte = pay_word[23:16];
                default: tx_byte = pay_word[31:24];
            endcase
        end
    end

    // R10: a refused byte stays in place
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(bidx)));

    // R5: write completion returns the engine to idle
    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> (st == ST_IDLE));
endmodule

// File: rtl/cmdq_pkt_engine.sv
module cmdq_pkt_engine
    import cmdq_pkg::*;
#(
    parameter int QDEPTH   = 64,
    parameter int RX_WORDS = 4,
    parameter int QSZ_W    = $clog2(QDEPTH),
    parameter int ADDR_W   = QSZ_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [2:0]        evt_set,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_byte,
    output logic              tx_last,
    input  logic              rx_valid,
    input  logic [31:0]       rx_word,
    output logic              irq
);
    logic [31:0]               qmem [QDEPTH];
    logic [1:0]                mode_r;
    logic [QSZ_W-1:0]          qsize_r;
    logic [N_FLAGS-1:0]        ien_r, stat_r, stat_set;
    logic [RX_WORDS-1:0][31:0] rx_regs;
    logic [QSZ_W-1:0]          qidx, raddr;
    logic                      is_q, reg_we, start_req, start_ok, rack_req;
    logic                      busy, wr_done, rx_done, arm_rx;

    assign is_q      = bus_addr[ADDR_W-1];
    assign raddr     = bus_addr[QSZ_W-1:0];
    assign reg_we    = bus_we && !is_q;
    assign start_req = reg_we && raddr == QSZ_W'(REG_CTRL) && bus_wdata[0];
    assign rack_req  = reg_we && raddr == QSZ_W'(REG_RACK) && bus_wdata[0];
    assign start_ok  = start_req && !busy && mode_r == 2'd0 && qsize_r != '0;

    always_comb begin
        stat_set           = '0;
        stat_set[FL_DONE]  = wr_done || rx_done;
        stat_set[FL_RDRDY] = rx_done;
        stat_set[FL_EVT0 +: 3] = evt_set;
        stat_set[FL_ERR]   = start_req && busy;
    end

    always_ff @(posedge clk) begin
        if (bus_we && is_q) qmem[raddr] <= bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_r  <= '0;
            qsize_r <= '0;
            ien_r   <= '0;
            stat_r  <= '0;
        end else begin
            if (reg_we && raddr == QSZ_W'(REG_MODE))  mode_r  <= bus_wdata[1:0];
            if (reg_we && raddr == QSZ_W'(REG_QSIZE)) qsize_r <= bus_wdata[QSZ_W-1:0];
            if (reg_we && raddr == QSZ_W'(REG_IEN))   ien_r   <= bus_wdata[N_FLAGS-1:0];
            if (reg_we && raddr == QSZ_W'(REG_STAT))
                stat_r <= (stat_r & bus_wdata[N_FLAGS-1:0]) | stat_set;
            else
                stat_r <= stat_r | stat_set;
        end
    end

    assign irq = |(stat_r & ien_r);

    always_comb begin
        bus_rdata = '0;
        if (is_q) begin
            bus_rdata = qmem[raddr];
        end else if (raddr >= QSZ_W'(REG_RXD0) && raddr < QSZ_W'(REG_RXD0 + RX_WORDS)) begin
            bus_rdata = rx_regs[raddr - QSZ_W'(REG_RXD0)];
        end else begin
            unique case (raddr)
                QSZ_W'(REG_MODE):  bus_rdata[1:0] = mode_r;
                QSZ_W'(REG_QSIZE): bus_rdata[QSZ_W-1:0] = qsize_r;
                QSZ_W'(REG_IEN):   bus_rdata[N_FLAGS-1:0] = ien_r;
                QSZ_W'(REG_STAT):  bus_rdata = {busy, {(31-N_FLAGS){1'b0}}, stat_r};
                default:           bus_rdata = '0;
            endcase
        end
    end

    cmdq_seq #(.QSZ_W(QSZ_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_ok (start_ok),
        .hdr_in   (qmem[0][31:8]),
        .cfg_long (qmem[0][CFG_LONG_BIT]),
        .cfg_read (qmem[0][CFG_READ_BIT]),
        .pay_word (qmem[qidx]),
        .qidx     (qidx),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte),
        .tx_last  (tx_last),
        .rx_done  (rx_done),
        .rack_req (rack_req),
        .arm_rx   (arm_rx),
        .wr_done  (wr_done),
        .busy     (busy)
    );

    cmdq_rxcap #(.RX_WORDS(RX_WORDS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm_rx),
        .rx_valid (rx_valid),
        .rx_word  (rx_word),
        .rx_regs  (rx_regs),
        .rx_done  (rx_done)
    );

    // R7: start during busy leaves the error flag set
    assert_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && busy) |=> stat_r[FL_ERR]);

    // R3: read-ready never rises without command done
    assert_rdy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_r[FL_RDRDY]) |-> stat_r[FL_DONE]);

    // R4: busy only drops after completion or acknowledge
    assert_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(wr_done || rack_req));
endmodule

// File: tb/cmdq_pkt_engine_tb_top.sv
module cmdq_pkt_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  evt_set = '0;
    logic        tx_valid, tx_last, irq;
    logic [7:0]  tx_byte;
    logic        tx_ready = 1'b1;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_word = '0;

    int vectors = 0, fails = 0, cyc = 0;
    bit finished = 0, bp_on = 0;

    always #10 clk = ~clk;

    cmdq_pkt_engine dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .tx_last(tx_last), .rx_valid(rx_valid), .rx_word(rx_word), .irq(irq)
    );

    // behavioural reference model
    int          m_phase = 0;
    logic [7:0]  exp_q[$];
    bit          m_read = 0;
    int          m_rxcnt = 0;
    logic [31:0] m_q [64];
    logic [31:0] m_rx [4];
    logic [1:0]  m_mode = 0;
    logic [5:0]  m_qsize = 0, m_en = 0, m_stat = 0;

    always @(posedge clk) begin : model
        logic [5:0] setv;
        bit was_busy;
        if (!rst_n) begin
            m_phase = 0; exp_q.delete(); m_mode = 0; m_qsize = 0; m_en = 0; m_stat = 0;
            for (int i = 0; i < 4; i++) m_rx[i] = 0;
        end else begin
            setv = 0;
            was_busy = (m_phase != 0);
            if (m_phase == 1 && tx_ready) begin
                void'(exp_q.pop_front());
                if (exp_q.size() == 0) begin
                    if (m_read) m_phase = 2;
                    else begin m_phase = 0; setv[1] = 1; end
                end
            end else if (m_phase == 2 && rx_valid) begin
                m_rx[m_rxcnt] = rx_word;
                m_rxcnt++;
                if (m_rxcnt == 4) begin m_phase = 3; setv[1:0] = 2'b11; end
            end else if (m_phase == 3 && bus_we && bus_addr == 7'd5 && bus_wdata[0]) begin
                m_phase = 0;
            end
            setv[4:2] = evt_set;
            if (bus_we) begin
                if (bus_addr[6]) m_q[bus_addr[5:0]] = bus_wdata;
                else case (bus_addr)
                    7'd0: if (bus_wdata[0]) begin
                        if (was_busy) setv[5] = 1;
                        else if (m_mode == 0 && m_qsize != 0) begin
                            exp_q.push_back(m_q[0][15:8]);
                            exp_q.push_back(m_q[0][23:16]);
                            exp_q.push_back(m_q[0][31:24]);
                            if (m_q[0][1])
                                for (int p = 0; p < int'(m_q[0][31:16]); p++)
                                    exp_q.push_back(m_q[1 + p/4][8*(p%4) +: 8]);
                            m_read = m_q[0][2];
                            m_rxcnt = 0;
                            m_phase = 1;
                        end
                    end
                    7'd1: m_mode = bus_wdata[1:0];
                    7'd2: m_qsize = bus_wdata[5:0];
                    7'd3: m_en = bus_wdata[5:0];
                    7'd4: m_stat = m_stat & bus_wdata[5:0];
                    default: ;
                endcase
            end
            m_stat = m_stat | setv;
        end
    end

    function automatic logic [31:0] model_read(input logic [6:0] a);
        if (a[6]) return m_q[a[5:0]];
        case (a)
            7'd1: return {30'b0, m_mode};
            7'd2: return {26'b0, m_qsize};
            7'd3: return {26'b0, m_en};
            7'd4: return {(m_phase != 0), 25'b0, m_stat};
            7'd8, 7'd9, 7'd10, 7'd11: return m_rx[a - 7'd8];
            default: return 32'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison of outputs
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2 tx_valid", {31'b0, tx_valid}, {31'b0, (m_phase == 1)});
            if (m_phase == 1 && tx_valid) begin
                check("R1 R2 R10 tx_byte", {24'b0, tx_byte}, {24'b0, exp_q[0]});
                check("R2 tx_last", {31'b0, tx_last}, {31'b0, (exp_q.size() == 1)});
            end
            check("R9 irq", {31'b0, irq}, {31'b0, |(m_stat & m_en)});
            tx_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
        end
    end

    task automatic summary();
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            fails++;
            $display("FAIL watchdog R4 actual=busy expected=idle");
            summary();
        end
    end

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd_chk(input logic [6:0] a, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, model_read(a));
    endtask

    task automatic wait_phase(input int ph);
        while (m_phase != ph) @(negedge clk);
    endtask

    task automatic rx_beat(input logic [31:0] w);
        @(negedge clk);
        rx_valid = 1; rx_word = w;
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic pulse_evt(input logic [2:0] e);
        @(negedge clk);
        evt_set = e;
        @(negedge clk);
        evt_set = 0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) m_q[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        rd_chk(7'd4, "R4 reset status");
        rd_chk(7'd3, "R9 reset enables");
        wr(7'd3, 32'h3f);

        // R1 R5: short write
        wr(7'd64, 32'hB2A11500);
        wr(7'd2, 32'd1);
        wr(7'd0, 32'd1);
        rd_chk(7'd4, "R4 busy during send");
        wait_phase(0);
        rd_chk(7'd4, "R5 done after short");
        wr(7'd4, 32'd0);
        rd_chk(7'd4, "R8 clear by zero");

        // R2 R10: long write of 7 bytes under backpressure
        wr(7'd64, {16'd7, 8'h39, 8'h02});
        wr(7'd65, 32'h44332211);
        wr(7'd66, 32'hEE776655);
        wr(7'd2, 32'd3);
        bp_on = 1;
        wr(7'd0, 32'd1);
        wait_phase(0);
        bp_on = 0;
        rd_chk(7'd4, "R5 done after long");

        // R2: long with zero payload
        wr(7'd64, {16'd0, 8'h29, 8'h02});
        wr(7'd0, 32'd1);
        wait_phase(0);

        // R3 R4 R7: turnaround read
        wr(7'd4, 32'd0);
        wr(7'd64, 32'h000A0604);
        wr(7'd2, 32'd1);
        wr(7'd0, 32'd1);
        wait_phase(2);
        wr(7'd0, 32'd1);
        rd_chk(7'd4, "R7 error flag");
        rx_beat(32'h0000AB21);
        rx_beat(32'h11111111);
        rx_beat(32'h22222222);
        rx_beat(32'h33333333);
        for (int k = 8; k < 12; k++) rd_chk(7'(k), "R3 read data");
        rd_chk(7'd4, "R3 R4 ready and still busy");
        wr(7'd5, 32'd1);
        rd_chk(7'd4, "R4 idle after ack");

        // R11: stray response words and acknowledge
        rx_beat(32'hDEADBEEF);
        rd_chk(7'd8, "R11 stray rx");
        wr(7'd5, 32'd1);
        rd_chk(7'd4, "R11 stray ack");

        // R6: gated starts
        wr(7'd1, 32'd3);
        wr(7'd0, 32'd1);
        rd_chk(7'd4, "R6 mode gate");
        wr(7'd1, 32'd0);
        wr(7'd2, 32'd0);
        wr(7'd0, 32'd1);
        rd_chk(7'd4, "R6 empty queue gate");
        rd_chk(7'd2, "R6 qsize");

        // R8 R9: events and masking
        wr(7'd4, 32'd0);
        wr(7'd3, 32'h04);
        pulse_evt(3'b110);
        rd_chk(7'd4, "R8 event bits");
        pulse_evt(3'b001);
        rd_chk(7'd4, "R9 enabled event");
        wr(7'd4, 32'hFFFFFFEF);
        rd_chk(7'd4, "R8 partial clear");
        repeat (3) @(negedge clk);
        summary();
    end
endmodule